// File: doc/BRIEF.md
# Half-Bridge Command Conditioner

This block sits between the pulse-width modulator and one leg of a power half-bridge. It takes two active-low switch commands, one for the high-side switch and one for the low-side switch, and produces two active-high gate enables. Each command passes through a glitch filter, so that a level counts only once it has held steady for a set number of clock cycles. A high-side request must also persist for a minimum time before it is honoured. The block then spaces every hand-over between the two switches by a deadtime, and it never lets both enables be on together.

A single `bridgeOff` input carries every upstream reason to stop the leg, such as over-current, under-voltage or an external shutdown. It forces both enables low on the next clock. It also restarts the deadtime, so a full gap follows its release. Three instances make a three-phase bridge. The timing windows are parameters in clock cycles. With a 100 MHz clock, the defaults give a 330 ns filter, a 230 ns deadtime and a 1 us total high-side qualification.

Top module: `hbLegConditioner`

## Requirements
- R1: After reset both gate enables are low and the deadtime counts as already expired, so a first request waits only for the filter.
- R2: The commands are active low: `hiCmdN` = 0 requests the high-side gate and `loCmdN` = 0 requests the low-side gate; a 1 means off.
- R3: A command level is accepted only after it has been held for FILT_CYC consecutive clock cycles. Shorter pulses, and short dropouts while a gate is on, have no effect. A low-side request held for P >= FILT_CYC cycles from idle raises `loGate` on the (FILT_CYC+2)-th clock edge after the input change and lowers it P edges later.
- R4: A filtered high-side request must persist for MIN_HI_CYC cycles. A high-side pulse of P < MIN_HI_CYC cycles never raises `hiGate`. For P >= MIN_HI_CYC, `hiGate` rises on edge FILT_CYC+MIN_HI_CYC+1 and falls on edge FILT_CYC+P+2.
- R5: After either gate enable falls, neither rises for DEAD_CYC cycles. A hand-over from high side to low side shows both low for exactly DEAD_CYC cycles when qualification is not the longer wait.
- R6: `hiGate` and `loGate` are never high in the same cycle.
- R7: While both filtered commands request on, both gates are held off. Once only one request remains, that side turns on through the normal path.
- R8: `bridgeOff` = 1 drives both gates low on the next clock edge and holds them low. After it returns to 0, a still-present request turns on no earlier than the DEAD_CYC-th edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hiCmdN | input | 1 | High-side command, active low |
| loCmdN | input | 1 | Low-side command, active low |
| bridgeOff | input | 1 | Force both gates off, active high |
| hiGate | output | 1 | High-side gate enable |
| loGate | output | 1 | Low-side gate enable |

## Verification
The hardest case to reach is a hand-over in which the deadtime, and not the filter or the high-side qualification, decides when the second gate rises. It needs one side fully on and then the two commands swapped on the same cycle. The bench does this with a short deadtime configuration, going from high side to low side, where the qualification is not in the way. Glitch rejection while a gate is already on takes a similar set-up: the bench holds the low side on and then opens dropouts of every length below the filter window.

// File: rtl/hbPkg.sv
package hbPkg;
  // strobes from control to datapath
  typedef struct packed {
    logic deadRestart;  // a gate just turned off or the leg is halted
    logic deadAdvance;  // both gates off: let the gap timer run
  } hbStrobe_t;
endpackage

// File: rtl/hbGlitchFilter.sv
module hbGlitchFilter #(
  parameter int   FILT_CYC    = 33,
  parameter logic RESET_LEVEL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic rawIn,
  output logic cleanOut
);
  localparam int FW = $clog2(FILT_CYC + 1);

  logic          sampled;
  logic [FW-1:0] runCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sampled  <= RESET_LEVEL;
      runCnt   <= '0;
      cleanOut <= RESET_LEVEL;
    end else begin
      sampled <= rawIn;
      if (sampled == cleanOut) begin
        runCnt <= '0;
      end else if (runCnt == FW'(FILT_CYC - 1)) begin
        cleanOut <= sampled;
        runCnt   <= '0;
      end else begin
        runCnt <= runCnt + 1'b1;
      end
    end
  end

  // R3: the clean level only ever takes the level seen at the input
  assert_filter_follows_R3: assert property (@(posedge clk) disable iff (rst)
    !$stable(cleanOut) |-> cleanOut == $past(sampled));
endmodule

// File: rtl/hbDatapath.sv
module hbDatapath #(
  parameter int FILT_CYC   = 33,
  parameter int DEAD_CYC   = 23,
  parameter int MIN_HI_CYC = 67
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hiCmdN,
  input  logic              loCmdN,
  input  hbPkg::hbStrobe_t  strobe,
  output logic              hiSeen,
  output logic              hiReady,
  output logic              loReq,
  output logic              deadDone
);
  localparam int QW = $clog2(MIN_HI_CYC + 1);
  localparam int DW = $clog2(DEAD_CYC + 1);

  logic [1:0] rawCmd;
  logic [1:0] cleanCmd;
  logic [QW-1:0] qualCnt;
  logic [DW-1:0] deadCnt;

  assign rawCmd = {loCmdN, hiCmdN};

  for (genvar ch = 0; ch < 2; ch++) begin : gFilt
    hbGlitchFilter #(.FILT_CYC(FILT_CYC), .RESET_LEVEL(1'b1)) i_filt (
      .clk(clk), .rst(rst), .rawIn(rawCmd[ch]), .cleanOut(cleanCmd[ch]));
  end

  // R2: commands are active low
  assign hiSeen = ~cleanCmd[0];
  assign loReq  = ~cleanCmd[1];

  // R4: high-side qualification timer
  always_ff @(posedge clk) begin
    if (rst || !hiSeen) qualCnt <= '0;
    else if (qualCnt != QW'(MIN_HI_CYC - 1)) qualCnt <= qualCnt + 1'b1;
  end
  assign hiReady = hiSeen && (qualCnt == QW'(MIN_HI_CYC - 1));

  // R1, R5: gap timer, starts expired
  always_ff @(posedge clk) begin
    if (rst) deadCnt <= DW'(DEAD_CYC - 1);
    else if (strobe.deadRestart) deadCnt <= '0;
    else if (strobe.deadAdvance && deadCnt != DW'(DEAD_CYC - 1)) deadCnt <= deadCnt + 1'b1;
  end
  assign deadDone = (deadCnt == DW'(DEAD_CYC - 1));

  // R5: a restart always opens a gap
  assert_gap_opens_R5: assert property (@(posedge clk) disable iff (rst)
    (strobe.deadRestart && DEAD_CYC > 1) |=> !deadDone);
endmodule

// File: rtl/hbControl.sv
module hbControl (
  input  logic              clk,
  input  logic              rst,
  input  logic              bridgeOff,
  input  logic              hiSeen,
  input  logic              hiReady,
  input  logic              loReq,
  input  logic              deadDone,
  output hbPkg::hbStrobe_t  strobe,
  output logic              hiGate,
  output logic              loGate
);
  logic wantHi;
  logic wantLo;

  // R7: a request counts only while the other side is silent
  assign wantHi = hiReady && !loReq;
  assign wantLo = loReq && !hiSeen;

  always_ff @(posedge clk) begin
    if (rst || bridgeOff) begin
      hiGate <= 1'b0;
      loGate <= 1'b0;
    end else if (hiGate) begin
      if (!wantHi) hiGate <= 1'b0;
    end else if (loGate) begin
      if (!wantLo) loGate <= 1'b0;
    end else if (deadDone) begin
      if (wantHi)      hiGate <= 1'b1;
      else if (wantLo) loGate <= 1'b1;
    end
  end

  always_comb begin
    strobe.deadRestart = bridgeOff || (hiGate && !wantHi) || (loGate && !wantLo);
    strobe.deadAdvance = !hiGate && !loGate;
  end

  assert_never_both_R6: assert property (@(posedge clk) disable iff (rst)
    !(hiGate && loGate));
  assert_halt_next_R8: assert property (@(posedge clk) disable iff (rst)
    bridgeOff |=> (!hiGate && !loGate));
  assert_rise_after_gap_R5: assert property (@(posedge clk) disable iff (rst)
    ($rose(hiGate) || $rose(loGate)) |-> $past(deadDone));
  assert_hi_qualified_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(hiGate) |-> $past(hiReady));
  assert_conflict_off_R7: assert property (@(posedge clk) disable iff (rst)
    (hiSeen && loReq) |=> (!hiGate && !loGate));
endmodule

// File: rtl/hbLegConditioner.sv
module hbLegConditioner #(
  parameter int FILT_CYC   = 33,
  parameter int DEAD_CYC   = 23,
  parameter int MIN_HI_CYC = 67
) (
  input  logic clk,
  input  logic rst,
  input  logic hiCmdN,
  input  logic loCmdN,
  input  logic bridgeOff,
  output logic hiGate,
  output logic loGate
);
  hbPkg::hbStrobe_t strobe;
  logic hiSeen;
  logic hiReady;
  logic loReq;
  logic deadDone;

  hbDatapath #(.FILT_CYC(FILT_CYC), .DEAD_CYC(DEAD_CYC), .MIN_HI_CYC(MIN_HI_CYC)) i_data (
    .clk(clk), .rst(rst), .hiCmdN(hiCmdN), .loCmdN(loCmdN), .strobe(strobe),
    .hiSeen(hiSeen), .hiReady(hiReady), .loReq(loReq), .deadDone(deadDone));

  hbControl i_ctrl (
    .clk(clk), .rst(rst), .bridgeOff(bridgeOff), .hiSeen(hiSeen), .hiReady(hiReady),
    .loReq(loReq), .deadDone(deadDone), .strobe(strobe), .hiGate(hiGate), .loGate(loGate));
endmodule

// File: tb/test_hbLegConditioner.sv
module test_hbLegConditioner;
  localparam int CLK_PERIOD = 10;
  localparam int F = 4;
  localparam int D = 3;
  localparam int M = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hiCmdN = 1'b1;
  logic loCmdN = 1'b1;
  logic bridgeOff = 1'b0;
  logic hiGate;
  logic loGate;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  int tick, hiRise, hiFall, loRise, loFall, bothSeen;
  logic prevHi, prevLo;

  always #(CLK_PERIOD/2) clk = ~clk;

  hbLegConditioner #(.FILT_CYC(F), .DEAD_CYC(D), .MIN_HI_CYC(M)) i_hbLegConditioner (
    .clk(clk), .rst(rst), .hiCmdN(hiCmdN), .loCmdN(loCmdN), .bridgeOff(bridgeOff),
    .hiGate(hiGate), .loGate(loGate));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic startWindow();
    tick = 0; hiRise = -1; hiFall = -1; loRise = -1; loFall = -1;
    prevHi = hiGate; prevLo = loGate;
  endtask

  task automatic step(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); @(negedge clk);
      tick++;
      if (hiGate && loGate) bothSeen++;
      if (hiGate && !prevHi && hiRise < 0) hiRise = tick;
      if (!hiGate && prevHi && hiFall < 0) hiFall = tick;
      if (loGate && !prevLo && loRise < 0) loRise = tick;
      if (!loGate && prevLo && loFall < 0) loFall = tick;
      prevHi = hiGate; prevLo = loGate;
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish();
  end

  initial begin
    bothSeen = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    startWindow();
    step(2);
    chk(hiGate == 0, "R1 hi reset", hiGate, 0);
    chk(loGate == 0, "R1 lo reset", loGate, 0);

    // R3, R1: low-side pulse sweep from idle
    for (int p = 1; p <= 8; p++) begin
      startWindow();
      loCmdN = 1'b0; step(p); loCmdN = 1'b1; step(25);
      if (p < F) chk(loRise == -1, "R3 short lo rejected", loRise, -1);
      else begin
        chk(loRise == F + 2, "R3 lo rise", loRise, F + 2);
        chk(loFall == F + 2 + p, "R3 lo fall", loFall, F + 2 + p);
      end
      chk(hiRise == -1, "R2 hi idle", hiRise, -1);
    end

    // R4, R2: high-side pulse sweep
    for (int p = 1; p <= 12; p++) begin
      startWindow();
      hiCmdN = 1'b0; step(p); hiCmdN = 1'b1; step(25);
      if (p < M) chk(hiRise == -1, "R4 short hi rejected", hiRise, -1);
      else begin
        chk(hiRise == F + M + 1, "R4 hi rise", hiRise, F + M + 1);
        chk(hiFall == F + p + 2, "R4 hi fall", hiFall, F + p + 2);
      end
      chk(loRise == -1, "R2 lo idle", loRise, -1);
    end

    // R3: dropouts shorter than the window while low side is on
    loCmdN = 1'b0; step(20);
    for (int p = 1; p < F; p++) begin
      startWindow();
      loCmdN = 1'b1; step(p); loCmdN = 1'b0; step(15);
      chk(loFall == -1 && loGate == 1, "R3 dropout ignored", loFall, -1);
    end

    // R5: low to high hand-over, qualification dominates
    startWindow();
    loCmdN = 1'b1; hiCmdN = 1'b0; step(25);
    chk(loFall == F + 2, "R5 lo off", loFall, F + 2);
    chk(hiRise == F + M + 1, "R5 hi after lo", hiRise, F + M + 1);

    // R5: high to low hand-over, deadtime dominates
    startWindow();
    hiCmdN = 1'b1; loCmdN = 1'b0; step(25);
    chk(hiFall == F + 2, "R5 hi off", hiFall, F + 2);
    chk(loRise == F + 2 + D, "R5 lo after gap", loRise, F + 2 + D);

    // R8: halt and release with low side requested
    startWindow();
    bridgeOff = 1'b1; step(1);
    chk(loGate == 0, "R8 halt next edge", loGate, 0);
    step(6);
    chk(loGate == 0 && hiGate == 0, "R8 held off", loGate, 0);
    startWindow();
    bridgeOff = 1'b0; step(12);
    chk(loRise == D, "R8 gap after release", loRise, D);

    // R7: both requested
    loCmdN = 1'b1; step(20);
    startWindow();
    loCmdN = 1'b0; hiCmdN = 1'b0; step(30);
    chk(hiRise == -1 && loRise == -1, "R7 conflict off", hiRise + loRise, -2);
    startWindow();
    hiCmdN = 1'b1; step(15);
    chk(loRise == F + 2, "R7 lo after conflict", loRise, F + 2);
    loCmdN = 1'b1; step(20);

    chk(bothSeen == 0, "R6 never both", bothSeen, 0);
    finish();
  end
endmodule